// File: doc/BRIEF.md
# Processor Operating Mode Register

This block is the 24-bit operating mode register of a processor core. It stores three byte-wide fields: chip mode in bits 7..0, extended mode in bits 15..8, and stack control/status in bits 23..16. While reset is held, the four external mode pins are copied into the lowest four bits. After reset, the core changes the register through an instruction port. That port supports three operations: a whole-register move, an AND with an 8-bit immediate on one selected byte, and an OR with an 8-bit immediate on one selected byte.

The block also watches the hardware stack. When the stack controller signals that spilling to extension memory has started, a sticky wrap flag is set. A push request made while the stack pointer equals the stack-size value, with the extension enabled, sets a sticky overflow flag. Each time the overflow flag goes from 0 to 1, the block raises a one-cycle request for the non-maskable stack-error exception. The meaning of the other mode bits belongs to the rest of the core; this block only stores them and shows them on the output.

Top module: `opmode_reg`

## Requirements
- R1: While `rst_n` is low, a rising clock edge loads `omr` with 0x000300 and places `mode_pins[3:0]` in `omr[3:0]`, pin bit 3 going to bit 3. The stack enable bit 20 and `stack_err_req` are 0.
- R2: When `op_kind`=1 (move), the register takes `op_wdata`, with reserved bits forced to 0, on the next edge.
- R3: Bits 23..21 and bit 5 are reserved. They always read 0, and no operation can set them.
- R4: When `op_kind`=2 (AND), the byte picked by `op_sel` is ANDed with `op_imm`. Select 0 picks bits 7..0, select 1 picks bits 15..8, and select 2 picks bits 23..16. The other bytes do not change, and select 3 changes nothing.
- R5: When `op_kind`=3 (OR), the selected byte is ORed with `op_imm`, with the same byte selection and the same untouched bytes as in R4.
- R6: When `op_kind`=0, bits 15..0 keep their value. After reset, `mode_pins` has no effect.
- R7: A `wrap_start` strobe sets bit 19 on the next edge.
- R8: Bit 18 is set on the next edge when `push_req` is 1, `sp_val` equals `stack_size` and bit 20 is 1. If any of these three conditions is missing, bit 18 is not set.
- R9: Bits 19 and 18 are sticky. Only reset, or an operation that writes bits 23..16, clears them. That means a move, or an AND or OR with select 2.
- R10: `stack_err_req` is high for exactly one cycle. That cycle is the first cycle in which bit 18 reads 1 after reading 0, whatever caused the change.
- R11: If a wrap or overflow event occurs in the same cycle as an operation that writes bits 23..16, the operation's value wins. An AND or OR on a lower byte does not block the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 4 | External mode select pins, sampled during reset |
| op_kind | input | 2 | 0 none, 1 move, 2 AND immediate, 3 OR immediate |
| op_sel | input | 2 | Byte select for AND and OR |
| op_imm | input | 8 | Immediate operand for AND and OR |
| op_wdata | input | 24 | Move data |
| push_req | input | 1 | Stack push request |
| sp_val | input | SP_W | Hardware stack pointer |
| stack_size | input | SP_W | Stack size value |
| wrap_start | input | 1 | Strobe: spill to extension memory begins |
| omr | output | 24 | Register contents |
| stack_err_req | output | 1 | Stack-error exception request pulse |

## Verification
The assertions assume that `op_kind`, `push_req` and `wrap_start` are driven to known values in every cycle once reset is released. They also assume that reset is held for at least one clock edge, so that the mode pins are captured before any check applies. The bench drives every input from a single task context at the falling clock edge. It returns `op_kind` to 0 after each operation and holds reset for three edges. In this way every property sees clean, single-cycle stimulus.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
   localparam int OMR_W      = 24;
   localparam int LANES      = OMR_W / 8;
   localparam int SEN_BIT    = 20;
   localparam int WRAP_BIT   = 19;
   localparam int EOV_BIT    = 18;
   localparam int STACK_LANE = 2;
   localparam int MODE_W     = 4;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_MOVE = 2'd1,
      OP_ANDI = 2'd2,
      OP_ORI  = 2'd3
   } op_kind_e;
endpackage

// File: rtl/opmode_sw_update.sv
module opmode_sw_update
   import opmode_pkg::*;
#(
   parameter logic [OMR_W-1:0] WR_MASK = 24'h1FFFDF
) (
   input  logic [OMR_W-1:0] cur,
   input  op_kind_e         op,
   input  logic [1:0]       sel,
   input  logic [7:0]       imm,
   input  logic [OMR_W-1:0] wdata,
   output logic [OMR_W-1:0] nxt,
   output logic             stack_lane_hit
);
   generate
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         logic [7:0] lane_cur;
         logic [7:0] lane_nxt;
         logic       lane_sel;
         assign lane_cur = cur[b*8 +: 8];
         assign lane_sel = (sel == 2'(b));
         always_comb begin
            lane_nxt = lane_cur;
            case (op)
               OP_MOVE: lane_nxt = wdata[b*8 +: 8];
               OP_ANDI: if (lane_sel) lane_nxt = lane_cur & imm;
               OP_ORI:  if (lane_sel) lane_nxt = lane_cur | imm;
               default: lane_nxt = lane_cur;
            endcase
         end
         assign nxt[b*8 +: 8] = lane_nxt & WR_MASK[b*8 +: 8];
      end
   endgenerate

   assign stack_lane_hit = (op == OP_MOVE) ||
                           (((op == OP_ANDI) || (op == OP_ORI)) && (sel == 2'(STACK_LANE)));
endmodule

// File: rtl/opmode_stack_mon.sv
module opmode_stack_mon #(
   parameter int SP_W = 6
) (
   input  logic            push_req,
   input  logic [SP_W-1:0] sp_val,
   input  logic [SP_W-1:0] stack_size,
   input  logic            ext_en,
   output logic            ovf_evt
);
   generate
      if (SP_W < 1 || SP_W > 16) begin : g_bad_width
         $error("opmode_stack_mon: SP_W must lie in 1..16");
      end
   endgenerate

   assign ovf_evt = push_req && ext_en && (sp_val == stack_size);
endmodule

// File: rtl/opmode_err_pulse.sv
module opmode_err_pulse #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_cur,
   input  logic flag_nxt,
   output logic err_req
);
   logic rise;
   assign rise = flag_nxt && !flag_cur;

   generate
      if (REGISTERED) begin : g_reg
         logic err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= rise;
         end
         assign err_req = err_q;
      end else begin : g_comb
         assign err_req = rise && rst_n;
      end
   endgenerate
endmodule

// File: rtl/opmode_reg.sv
module opmode_reg
   import opmode_pkg::*;
#(
   parameter int               SP_W       = 6,
   parameter logic [OMR_W-1:0] RESET_VAL  = 24'h000300,
   parameter logic [OMR_W-1:0] WR_MASK    = 24'h1FFFDF,
   parameter bit               ERR_REG    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      mode_pins,
   input  logic [1:0]      op_kind,
   input  logic [1:0]      op_sel,
   input  logic [7:0]      op_imm,
   input  logic [23:0]     op_wdata,
   input  logic            push_req,
   input  logic [SP_W-1:0] sp_val,
   input  logic [SP_W-1:0] stack_size,
   input  logic            wrap_start,
   output logic [23:0]     omr,
   output logic            stack_err_req
);
   localparam logic [OMR_W-1:0] MODE_FIELD = OMR_W'((1 << MODE_W) - 1);
   localparam logic [OMR_W-1:0] FLAG_BITS  = (OMR_W'(1) << WRAP_BIT) | (OMR_W'(1) << EOV_BIT);
   localparam logic [OMR_W-1:0] NEED_BITS  = FLAG_BITS | (OMR_W'(1) << SEN_BIT) | MODE_FIELD;

   generate
      if ((RESET_VAL & ~WR_MASK) != '0) begin : g_bad_reset
         $error("opmode_reg: RESET_VAL sets reserved bits");
      end
      if ((WR_MASK & NEED_BITS) != NEED_BITS) begin : g_bad_mask
         $error("opmode_reg: WR_MASK must keep the flag, enable and mode bits");
      end
   endgenerate

   op_kind_e         op;
   logic [OMR_W-1:0] omr_q;
   logic [OMR_W-1:0] sw_nxt;
   logic [OMR_W-1:0] hw_nxt;
   logic [OMR_W-1:0] omr_d;
   logic             hi_hit;
   logic             ovf_evt;

   assign op = op_kind_e'(op_kind);

   opmode_sw_update #(.WR_MASK(WR_MASK)) u_sw (
      .cur            (omr_q),
      .op             (op),
      .sel            (op_sel),
      .imm            (op_imm),
      .wdata          (op_wdata),
      .nxt            (sw_nxt),
      .stack_lane_hit (hi_hit)
   );

   opmode_stack_mon #(.SP_W(SP_W)) u_mon (
      .push_req   (push_req),
      .sp_val     (sp_val),
      .stack_size (stack_size),
      .ext_en     (omr_q[SEN_BIT]),
      .ovf_evt    (ovf_evt)
   );

   always_comb begin
      hw_nxt = omr_q;
      if (wrap_start) hw_nxt[WRAP_BIT] = 1'b1;
      if (ovf_evt)    hw_nxt[EOV_BIT]  = 1'b1;
   end

   always_comb begin
      if (hi_hit) omr_d = sw_nxt;
      else        omr_d = {hw_nxt[OMR_W-1:16], sw_nxt[15:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) omr_q <= (RESET_VAL & ~MODE_FIELD) | OMR_W'(mode_pins);
      else        omr_q <= omr_d;
   end

   opmode_err_pulse #(.REGISTERED(ERR_REG)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_cur (omr_q[EOV_BIT]),
      .flag_nxt (omr_d[EOV_BIT]),
      .err_req  (stack_err_req)
   );

   assign omr = omr_q;

   // R2
   assert_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MOVE) |=> (omr_q == ($past(op_wdata) & WR_MASK)));
   // R3
   assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((omr & ~WR_MASK) == '0));
   // R6
   assert_low_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE) |=> $stable(omr_q[15:0]));
   // R7
   assert_wrap_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_start && !hi_hit) |=> omr_q[WRAP_BIT]);
   // R8
   assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !hi_hit) |=> omr_q[EOV_BIT]);
   // R9
   assert_sticky_eov_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (omr_q[EOV_BIT] && !hi_hit) |=> omr_q[EOV_BIT]);
   assert_sticky_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (omr_q[WRAP_BIT] && !hi_hit) |=> omr_q[WRAP_BIT]);
   // R11
   assert_move_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_MOVE) && (wrap_start || ovf_evt)) |=>
         (omr_q[WRAP_BIT:EOV_BIT] == $past(op_wdata[WRAP_BIT:EOV_BIT])));

   generate
      if (ERR_REG) begin : g_err_chk
         // R10
         assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
            stack_err_req |=> !stack_err_req);
         assert_err_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(omr_q[EOV_BIT]) |-> stack_err_req);
         assert_err_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
            stack_err_req |-> omr_q[EOV_BIT]);
      end
   endgenerate
endmodule

// File: tb/sim_opmode_reg.sv
`timescale 1ns/1ps
module sim_opmode_reg;
   localparam int SP_W = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      mode_pins = 4'h0;
   logic [1:0]      op_kind = 2'd0;
   logic [1:0]      op_sel = 2'd0;
   logic [7:0]      op_imm = 8'h00;
   logic [23:0]     op_wdata = 24'h0;
   logic            push_req = 1'b0;
   logic [SP_W-1:0] sp_val = '0;
   logic [SP_W-1:0] stack_size = '0;
   logic            wrap_start = 1'b0;
   logic [23:0]     omr;
   logic            stack_err_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   opmode_reg #(.SP_W(SP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .op_kind(op_kind),
      .op_sel(op_sel), .op_imm(op_imm), .op_wdata(op_wdata), .push_req(push_req),
      .sp_val(sp_val), .stack_size(stack_size), .wrap_start(wrap_start),
      .omr(omr), .stack_err_req(stack_err_req)
   );

   localparam logic [23:0] KEEP = 24'h1FFFDF;

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [3:0] pins);
      rst_n = 1'b0;
      mode_pins = pins;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_op(input logic [1:0] k, input logic [1:0] s,
                        input logic [7:0] imm, input logic [23:0] wd);
      op_kind = k; op_sel = s; op_imm = imm; op_wdata = wd;
      @(negedge clk);
      op_kind = 2'd0;
   endtask

   task automatic t_reset;
      do_reset(4'b1010);
      chk("R1 pins 1010", omr, 24'h00030A);
      chk("R1 err low", {23'd0, stack_err_req}, 24'h0);
      do_reset(4'b0101);
      chk("R1 pins 0101", omr, 24'h000305);
      chk("R1 enable clear", {23'd0, omr[20]}, 24'h0);
   endtask

   task automatic t_move;
      do_op(2'd1, 2'd0, 8'h00, 24'h123456);
      chk("R2 move", omr, 24'h123456);
      do_op(2'd1, 2'd0, 8'h00, 24'hFFFFFF);
      chk("R3 reserved masked on move", omr, 24'hFFFFFF & KEEP);
      chk("R3 reserved zero", omr & ~KEEP, 24'h0);
   endtask

   task automatic t_andor;
      do_op(2'd1, 2'd0, 8'h00, 24'h1FFFDF);
      do_op(2'd2, 2'd1, 8'h0F, 24'h0);
      chk("R4 and middle byte", omr, 24'h1F0FDF);
      do_op(2'd2, 2'd3, 8'h00, 24'h0);
      chk("R4 select 3 no change", omr, 24'h1F0FDF);
      do_op(2'd1, 2'd0, 8'h00, 24'h000000);
      do_op(2'd3, 2'd0, 8'hFF, 24'h0);
      chk("R5 or low byte, bit5 reserved", omr, 24'h0000DF);
      do_op(2'd3, 2'd2, 8'hFF, 24'h0);
      chk("R5 or high byte", omr, 24'h1F00DF);
      do_op(2'd2, 2'd2, 8'h00, 24'h0);
      chk("R4 and high byte clears flags", omr, 24'h0000DF);
   endtask

   task automatic t_hold;
      do_op(2'd1, 2'd0, 8'h00, 24'h00A5C3);
      mode_pins = 4'b1111;
      repeat (4) @(negedge clk);
      chk("R6 hold, pins ignored", omr, 24'h00A5C3 & KEEP);
   endtask

   task automatic t_wrap;
      do_op(2'd1, 2'd0, 8'h00, 24'h0);
      wrap_start = 1'b1;
      @(negedge clk);
      wrap_start = 1'b0;
      chk("R7 wrap set", omr, 24'h080000);
      repeat (3) @(negedge clk);
      do_op(2'd3, 2'd0, 8'h01, 24'h0);
      chk("R9 wrap sticky over low op", omr, 24'h080001);
      do_op(2'd1, 2'd0, 8'h00, 24'h0);
      chk("R9 wrap cleared by move", omr, 24'h0);
   endtask

   task automatic t_overflow;
      do_op(2'd1, 2'd0, 8'h00, 24'h100000);
      sp_val = 6'd3; stack_size = 6'd5; push_req = 1'b1;
      @(negedge clk);
      push_req = 1'b0;
      chk("R8 no set when sp differs", omr, 24'h100000);
      sp_val = 6'd5; push_req = 1'b1;
      @(negedge clk);
      push_req = 1'b0;
      chk("R8 overflow set", omr, 24'h140000);
      chk("R10 err pulse high", {23'd0, stack_err_req}, 24'h1);
      @(negedge clk);
      chk("R10 err pulse one cycle", {23'd0, stack_err_req}, 24'h0);
      push_req = 1'b1;
      @(negedge clk);
      push_req = 1'b0;
      chk("R10 no pulse when already set", {23'd0, stack_err_req}, 24'h0);
      chk("R9 overflow sticky", omr, 24'h140000);
      do_op(2'd1, 2'd0, 8'h00, 24'h000000);
      push_req = 1'b1;
      @(negedge clk);
      push_req = 1'b0;
      chk("R8 no set with enable off", omr, 24'h0);
      do_op(2'd1, 2'd0, 8'h00, 24'h040000);
      chk("R10 pulse on written rise", {23'd0, stack_err_req}, 24'h1);
   endtask

   task automatic t_priority;
      do_op(2'd1, 2'd0, 8'h00, 24'h100000);
      sp_val = 6'd7; stack_size = 6'd7;
      push_req = 1'b1; wrap_start = 1'b1;
      do_op(2'd1, 2'd0, 8'h00, 24'h000011);
      push_req = 1'b0; wrap_start = 1'b0;
      chk("R11 move wins over events", omr, 24'h000011);
      chk("R11 no pulse", {23'd0, stack_err_req}, 24'h0);
      do_op(2'd1, 2'd0, 8'h00, 24'h100000);
      push_req = 1'b1; wrap_start = 1'b1;
      do_op(2'd2, 2'd0, 8'h00, 24'h0);
      push_req = 1'b0; wrap_start = 1'b0;
      chk("R11 low-byte and lets events through", omr, 24'h1C0000);
   endtask

   initial begin
      t_reset();
      t_move();
      t_andor();
      t_hold();
      t_wrap();
      t_overflow();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule